// File: doc/BRIEF.md
# Keyed Serial Access Gate for a Clock Register File

This block sits on a memory bus beside an SRAM or ROM and shares that memory's chip-enable, output-enable, write-enable and data-input lines. It gives the bus access to a 64-bit clock register file without taking any address space. An access is counted when its strobe is released. While locked, the gate forwards chip enable to the attached memory and watches write cycles for a 64-bit unlock key, one data bit per write. Any read cycle restarts the key search. The key is the bytes C5, 3A, A3, 5C, C5, 3A, A3, 5C, with the bits of each byte taken LSB first.

After the last key bit matches, the next 64 chip-enabled accesses form a serial transfer with the register file, and the memory chip enable is held inactive for that time. Transfer position k is bit k of the flat 64-bit register port, which is bit k mod 8 of register k/8, so register 0 bit 0 comes first and register 7 bit 7 comes last. Reads drive the addressed bit out. Writes collect in a shadow frame, which is handed to the register file as one parallel commit. A power-fail input aborts any key search or transfer. It also forces the memory chip enable to the level that suits RAM or ROM.

Top module: `keyed_serial_port`

## Requirements
- R1: With power good and no transfer active, ce_no equals ce_ni in the same cycle, whatever the other strobes do.
- R2: An access is chip-enabled (ce_ni low). A write is we_ni low. A read is oe_ni low with we_ni high. An access completes when its strobe is released. Sixty-four chip-enabled writes whose d_i bits match the key unlock the gate. The key bit for write i is bit i of 64'h5CA33AC55CA33AC5, which is bytes C5,3A,A3,5C,C5,3A,A3,5C, LSB first.
- R3: A write whose bit differs from the key bit at the pointer leaves the pointer where it is and marks the search failed. All later writes are then ignored until a read, so the gate stays locked.
- R4: A chip-enabled read completing during the key search sends the pointer back to key bit 0, and partial progress is lost.
- R5: Strobes given while ce_ni is high change neither the key pointer nor the transfer position.
- R6: From unlock until the 64th transfer access completes, ce_no is held high. Afterwards the gate is back in key search, and ce_no follows ce_ni again.
- R7: The k-th transfer access (k = 0..63), if a read, drives regs_rdata_i[k] on dq_o with dq_oe_o high. The port value is captured at unlock. dq_oe_o is low outside transfer reads.
- R8: When the 64th transfer access is a write, regs_wr_o pulses for one cycle. regs_wdata_o then carries the written bits at their positions, and the captured register values at positions that were read.
- R9: A transfer whose 64th access is a read produces no commit.
- R10: Power fail (pwr_fail_i high) aborts a transfer or key search with no commit. Accesses made during power fail are ignored, and after power returns the gate starts from key bit 0.
- R11: During power fail, ce_no is high when rom_mode_i is 0 (RAM) and low when rom_mode_i is 1 (ROM).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; bus strobes are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_ni | input | 1 | Chip enable from the bus, active low |
| oe_ni | input | 1 | Output enable from the bus, active low |
| we_ni | input | 1 | Write enable from the bus, active low |
| d_i | input | 1 | Serial data input bit |
| pwr_fail_i | input | 1 | Power-fail indication, active high |
| rom_mode_i | input | 1 | 1 selects ROM mode, 0 selects RAM mode |
| ce_no | output | 1 | Chip enable to the attached memory, active low |
| dq_o | output | 1 | Serial data output bit |
| dq_oe_o | output | 1 | Drive enable for dq_o |
| regs_rdata_i | input | 64 | Parallel value of the clock register file |
| regs_wr_o | output | 1 | One-cycle commit strobe to the register file |
| regs_wdata_o | output | 64 | Frame committed with regs_wr_o |

## Verification
The properties assume that the bus strobes are synchronous to clk_i and stay stable for at least one full clock per phase. They also assume that write and read accesses do not overlap. The bench drives every strobe change on the falling edge and holds each strobe active for two clocks and inactive for two more, so each access is seen exactly once. Power fail is raised and dropped only between accesses. The key-mismatch sweep places the wrong bit at each of the 64 key positions in turn.

// File: rtl/ksp_pkg.sv
package ksp_pkg;
  typedef enum logic {
    MODE_HUNT = 1'b0,
    MODE_XFER = 1'b1
  } gate_mode_e;

  // C5,3A,A3,5C twice; byte 0 in [7:0], LSB matched first
  localparam logic [63:0] KEY_DEFAULT = 64'h5CA3_3AC5_5CA3_3AC5;
endpackage

// File: rtl/ksp_strobe_sampler.sv
module ksp_strobe_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic oe_ni,
  input  logic we_ni,
  input  logic d_i,
  input  logic pwr_fail_i,
  output logic rd_live_o,
  output logic rd_done_o,
  output logic wr_done_o,
  output logic bit_o
);
  logic wr_live;
  logic rd_s, wr_s, d_s;
  logic rd_p, wr_p, d_p;

  // write wins when both strobes are low
  assign rd_live_o = ~ce_ni & ~oe_ni & we_ni & ~pwr_fail_i;
  assign wr_live   = ~ce_ni & ~we_ni & ~pwr_fail_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_s <= 1'b0;
      wr_s <= 1'b0;
      d_s  <= 1'b0;
      rd_p <= 1'b0;
      wr_p <= 1'b0;
      d_p  <= 1'b0;
    end else if (pwr_fail_i) begin
      rd_s <= 1'b0;
      wr_s <= 1'b0;
      d_s  <= 1'b0;
      rd_p <= 1'b0;
      wr_p <= 1'b0;
      d_p  <= 1'b0;
    end else begin
      rd_s <= rd_live_o;
      wr_s <= wr_live;
      d_s  <= d_i;
      rd_p <= rd_s;
      wr_p <= wr_s;
      d_p  <= d_s;
    end
  end

  // access completes on strobe release
  assign rd_done_o = rd_p & ~rd_s;
  assign wr_done_o = wr_p & ~wr_s;
  assign bit_o     = d_p;
endmodule

// File: rtl/ksp_key_matcher.sv
module ksp_key_matcher #(
  parameter int unsigned          KEY_BITS = 64,
  parameter logic [KEY_BITS-1:0]  KEY      = ksp_pkg::KEY_DEFAULT,
  localparam int unsigned         PTR_W    = $clog2(KEY_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hunt_i,
  input  logic             pwr_fail_i,
  input  logic             rd_done_i,
  input  logic             wr_done_i,
  input  logic             bit_i,
  output logic             unlock_o,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(KEY_BITS - 1);

  logic [PTR_W-1:0] ptr_q;
  logic             miss_q;
  logic             hit;

  assign hit = (bit_i == KEY[ptr_q]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      miss_q <= 1'b0;
    end else if (pwr_fail_i || !hunt_i || rd_done_i) begin
      ptr_q  <= '0;
      miss_q <= 1'b0;
    end else if (wr_done_i && !miss_q) begin
      if (!hit)                  miss_q <= 1'b1;
      else if (ptr_q == PTR_LAST) ptr_q <= '0;
      else                       ptr_q  <= ptr_q + 1'b1;
    end
  end

  assign unlock_o = hunt_i & ~pwr_fail_i & ~rd_done_i & wr_done_i &
                    ~miss_q & hit & (ptr_q == PTR_LAST);
  assign ptr_o    = ptr_q;
endmodule

// File: rtl/ksp_xfer_engine.sv
module ksp_xfer_engine #(
  parameter int unsigned  XFER_BITS = 64,
  localparam int unsigned CNT_W     = $clog2(XFER_BITS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pwr_fail_i,
  input  logic                 unlock_i,
  input  logic                 rd_done_i,
  input  logic                 wr_done_i,
  input  logic                 bit_i,
  input  logic [XFER_BITS-1:0] rdata_i,
  output logic                 active_o,
  output logic                 dq_bit_o,
  output logic                 commit_o,
  output logic [XFER_BITS-1:0] commit_data_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(XFER_BITS - 1);

  logic                 active_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [XFER_BITS-1:0] frame_q;
  logic                 step;

  assign step = active_q & ~pwr_fail_i & (rd_done_i | wr_done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      frame_q  <= '0;
    end else if (pwr_fail_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (unlock_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      frame_q  <= rdata_i;
    end else if (step) begin
      if (wr_done_i) frame_q[cnt_q] <= bit_i;
      if (cnt_q == CNT_LAST) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // final bit is still in flight when the commit fires
  always_comb begin
    commit_data_o = frame_q;
    commit_data_o[XFER_BITS-1] = bit_i;
  end

  assign commit_o = step & wr_done_i & (cnt_q == CNT_LAST);
  assign active_o = active_q;
  assign dq_bit_o = frame_q[cnt_q];
endmodule

// File: rtl/ksp_ce_gate.sv
module ksp_ce_gate (
  input  logic ce_ni,
  input  logic pwr_fail_i,
  input  logic rom_mode_i,
  input  logic xfer_i,
  output logic ce_no
);
  always_comb begin
    if (pwr_fail_i)  ce_no = ~rom_mode_i;
    else if (xfer_i) ce_no = 1'b1;
    else             ce_no = ce_ni;
  end
endmodule

// File: rtl/keyed_serial_port.sv
module keyed_serial_port #(
  parameter int unsigned          KEY_BITS  = 64,
  parameter logic [KEY_BITS-1:0]  KEY       = ksp_pkg::KEY_DEFAULT,
  parameter int unsigned          XFER_BITS = 64,
  localparam int unsigned         PTR_W     = $clog2(KEY_BITS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ce_ni,
  input  logic                 oe_ni,
  input  logic                 we_ni,
  input  logic                 d_i,
  input  logic                 pwr_fail_i,
  input  logic                 rom_mode_i,
  output logic                 ce_no,
  output logic                 dq_o,
  output logic                 dq_oe_o,
  input  logic [XFER_BITS-1:0] regs_rdata_i,
  output logic                 regs_wr_o,
  output logic [XFER_BITS-1:0] regs_wdata_o
);
  import ksp_pkg::*;

  logic             rd_live, rd_done, wr_done, bus_bit;
  logic             unlock, xfer_act, dq_bit;
  logic [PTR_W-1:0] key_ptr;
  gate_mode_e       mode;

  assign mode = xfer_act ? MODE_XFER : MODE_HUNT;

  ksp_strobe_sampler u_sampler (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_ni      (ce_ni),
    .oe_ni      (oe_ni),
    .we_ni      (we_ni),
    .d_i        (d_i),
    .pwr_fail_i (pwr_fail_i),
    .rd_live_o  (rd_live),
    .rd_done_o  (rd_done),
    .wr_done_o  (wr_done),
    .bit_o      (bus_bit)
  );

  ksp_key_matcher #(
    .KEY_BITS (KEY_BITS),
    .KEY      (KEY)
  ) u_matcher (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hunt_i     (mode == MODE_HUNT),
    .pwr_fail_i (pwr_fail_i),
    .rd_done_i  (rd_done),
    .wr_done_i  (wr_done),
    .bit_i      (bus_bit),
    .unlock_o   (unlock),
    .ptr_o      (key_ptr)
  );

  ksp_xfer_engine #(
    .XFER_BITS (XFER_BITS)
  ) u_xfer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pwr_fail_i    (pwr_fail_i),
    .unlock_i      (unlock),
    .rd_done_i     (rd_done),
    .wr_done_i     (wr_done),
    .bit_i         (bus_bit),
    .rdata_i       (regs_rdata_i),
    .active_o      (xfer_act),
    .dq_bit_o      (dq_bit),
    .commit_o      (regs_wr_o),
    .commit_data_o (regs_wdata_o)
  );

  ksp_ce_gate u_ce_gate (
    .ce_ni      (ce_ni),
    .pwr_fail_i (pwr_fail_i),
    .rom_mode_i (rom_mode_i),
    .xfer_i     (mode == MODE_XFER),
    .ce_no      (ce_no)
  );

  assign dq_oe_o = (mode == MODE_XFER) & rd_live;
  assign dq_o    = dq_bit;
endmodule

// File: rtl/ksp_checker.sv
module ksp_checker #(
  parameter int unsigned PTR_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ce_ni,
  input logic             oe_ni,
  input logic             pwr_fail_i,
  input logic             rom_mode_i,
  input logic             ce_no,
  input logic             dq_oe_o,
  input logic             regs_wr_o,
  input logic             xfer_act,
  input logic [PTR_W-1:0] key_ptr
);
  assert_ce_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_fail_i && !xfer_act) |-> (ce_no == ce_ni));

  assert_ce_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_fail_i && xfer_act) |-> ce_no);

  assert_ce_ram_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_fail_i && !rom_mode_i) |-> ce_no);

  assert_ce_rom_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_fail_i && rom_mode_i) |-> !ce_no);

  assert_no_commit_pf_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_fail_i |-> !regs_wr_o);

  assert_abort_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_fail_i |=> (!xfer_act && key_ptr == '0));

  assert_ptr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_ptr != $past(key_ptr)) |-> (key_ptr == $past(key_ptr) + 1'b1 || key_ptr == '0));

  assert_drive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (xfer_act && !ce_ni && !oe_ni && ce_no));

  assert_commit_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_wr_o |=> !xfer_act);
endmodule

bind keyed_serial_port ksp_checker #(.PTR_W(PTR_W)) u_ksp_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ce_ni      (ce_ni),
  .oe_ni      (oe_ni),
  .pwr_fail_i (pwr_fail_i),
  .rom_mode_i (rom_mode_i),
  .ce_no      (ce_no),
  .dq_oe_o    (dq_oe_o),
  .regs_wr_o  (regs_wr_o),
  .xfer_act   (xfer_act),
  .key_ptr    (key_ptr)
);

// File: tb/keyed_serial_port_test.sv
module keyed_serial_port_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] KEY  = 64'h5CA3_3AC5_5CA3_3AC5;
  localparam logic [63:0] PAT  = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] WPAT = 64'hF00D_CAFE_1357_9BDF;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ce_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1, d_i = 1'b0;
  logic pwr_fail_i = 1'b0, rom_mode_i = 1'b0;
  logic ce_no, dq_o, dq_oe_o, regs_wr_o;
  logic [63:0] regs_wdata_o;
  logic [63:0] regs_rdata_i = PAT;

  int n_vec = 0, n_bad = 0;
  int commits = 0;
  logic [63:0] last_commit = '0;

  logic s_dq, s_oe, s_ce;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_serial_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ce_ni), .oe_ni(oe_ni), .we_ni(we_ni),
    .d_i(d_i), .pwr_fail_i(pwr_fail_i), .rom_mode_i(rom_mode_i), .ce_no(ce_no),
    .dq_o(dq_o), .dq_oe_o(dq_oe_o), .regs_rdata_i(regs_rdata_i),
    .regs_wr_o(regs_wr_o), .regs_wdata_o(regs_wdata_o)
  );

  always @(negedge clk) if (regs_wr_o) begin
    commits++;
    last_commit = regs_wdata_o;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_cyc(input logic b, input logic with_ce);
    @(negedge clk);
    ce_ni = ~with_ce; we_ni = 1'b0; d_i = b;
    repeat (2) @(negedge clk);
    ce_ni = 1'b1; we_ni = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd_cyc(input logic with_ce);
    @(negedge clk);
    ce_ni = ~with_ce; oe_ni = 1'b0;
    @(negedge clk);
    s_dq = dq_o; s_oe = dq_oe_o; s_ce = ce_no;
    @(negedge clk);
    ce_ni = 1'b1; oe_ni = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_key(input int from, input int upto);
    for (int i = from; i < upto; i++) wr_cyc(KEY[i], 1'b1);
  endtask

  task automatic unlock();
    rd_cyc(1'b1);
    send_key(0, 64);
  endtask

  task automatic expect_locked(input string req);
    rd_cyc(1'b1);
    chk(req, {62'd0, s_ce, s_oe}, 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // reset state and pass-through
    chk("R1 idle ce high", {63'd0, ce_no}, 64'd1);
    ce_ni = 1'b0;
    #1 chk("R1 ce follows low", {61'd0, ce_no, dq_oe_o, regs_wr_o}, 64'd0);
    ce_ni = 1'b1;

    // R2 R7 R6 R9: unlock and read whole register file
    unlock();
    for (int k = 0; k < 64; k++) begin
      rd_cyc(1'b1);
      chk($sformatf("R7 read bit %0d", k), {62'd0, s_dq, s_oe}, {62'd0, PAT[k], 1'b1});
      chk("R6 ce held", {63'd0, s_ce}, 64'd1);
    end
    chk("R9 read-only no commit", 64'(commits), 64'd0);
    expect_locked("R6 back to hunt");

    // R8 full write transfer
    unlock();
    for (int k = 0; k < 64; k++) wr_cyc(WPAT[k], 1'b1);
    chk("R8 one commit", 64'(commits), 64'd1);
    chk("R8 commit data", last_commit, WPAT);

    // R8 mixed: reads low half, writes high half
    regs_rdata_i = ~PAT;
    unlock();
    regs_rdata_i = PAT;
    for (int k = 0; k < 32; k++) begin
      rd_cyc(1'b1);
      chk("R7 captured at unlock", {63'd0, s_dq}, {63'd0, ~PAT[k]});
    end
    for (int k = 32; k < 64; k++) wr_cyc(WPAT[k], 1'b1);
    chk("R8 mixed commit", 64'(commits), 64'd2);
    chk("R8 mixed data", last_commit, {WPAT[63:32], ~PAT[31:0]});

    // R9 last access is a read
    unlock();
    for (int k = 0; k < 63; k++) wr_cyc(WPAT[k], 1'b1);
    rd_cyc(1'b1);
    chk("R9 last read", {62'd0, s_dq, s_oe}, {62'd0, PAT[63], 1'b1});
    chk("R9 no commit", 64'(commits), 64'd2);
    expect_locked("R9 transfer closed");

    // R3 mismatch at each key position
    for (int p = 0; p < 64; p++) begin
      rd_cyc(1'b1);
      for (int i = 0; i < 64; i++) wr_cyc(KEY[i] ^ (i == p), 1'b1);
      expect_locked($sformatf("R3 mismatch at %0d", p));
    end
    // read restarts search
    unlock();
    rd_cyc(1'b1);
    chk("R3 read restarts key", {61'd0, s_ce, s_oe, s_dq}, {61'd0, 1'b1, 1'b1, PAT[0]});
    for (int k = 1; k < 64; k++) rd_cyc(1'b1);

    // R4 read mid-key loses progress
    rd_cyc(1'b1);
    send_key(0, 20);
    rd_cyc(1'b1);
    chk("R4 mid-key read passes", {62'd0, s_ce, s_oe}, 64'd0);
    send_key(20, 64);
    expect_locked("R4 partial key rejected");

    // R5 strobes without chip enable are ignored
    rd_cyc(1'b1);
    for (int i = 0; i < 64; i++) begin
      wr_cyc(~KEY[i], 1'b0);
      rd_cyc(1'b0);
      wr_cyc(KEY[i], 1'b1);
    end
    rd_cyc(1'b0);
    rd_cyc(1'b1);
    chk("R5 unlocked, position 0", {61'd0, s_ce, s_oe, s_dq}, {61'd0, 1'b1, 1'b1, PAT[0]});
    wr_cyc(1'b0, 1'b0);
    rd_cyc(1'b1);
    chk("R5 position 1", {63'd0, s_dq}, {63'd0, PAT[1]});
    for (int k = 2; k < 64; k++) rd_cyc(1'b1);

    // R10 R11 power fail mid-transfer
    c0 = commits;
    unlock();
    for (int k = 0; k < 30; k++) wr_cyc(WPAT[k], 1'b1);
    @(negedge clk);
    pwr_fail_i = 1'b1; rom_mode_i = 1'b0; ce_ni = 1'b0;
    @(negedge clk);
    chk("R11 RAM forces high", {62'd0, ce_no, dq_oe_o}, 64'd2);
    rom_mode_i = 1'b1;
    #1 chk("R11 ROM forces low", {63'd0, ce_no}, 64'd0);
    ce_ni = 1'b1;
    #1 chk("R11 ROM low with ce high", {63'd0, ce_no}, 64'd0);
    for (int k = 30; k < 64; k++) wr_cyc(WPAT[k], 1'b1);
    @(negedge clk);
    pwr_fail_i = 1'b0; rom_mode_i = 1'b0;
    @(negedge clk);
    chk("R10 no commit", 64'(commits - c0), 64'd0);
    expect_locked("R10 aborted to hunt");

    // R10 power fail during key search
    rd_cyc(1'b1);
    send_key(0, 40);
    @(negedge clk); pwr_fail_i = 1'b1;
    repeat (2) @(negedge clk); pwr_fail_i = 1'b0;
    send_key(40, 64);
    expect_locked("R10 key restarts after fail");
    unlock();
    for (int k = 0; k < 64; k++) wr_cyc(PAT[k], 1'b1);
    chk("R10 recovery commit", last_commit, PAT);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule